// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a 256-byte serial memory that answers on a two-wire (I2C-style) bus as a slave. It watches the serial clock and data lines, which reach it already synchronized to a fast system clock. It finds Start and Stop conditions and shifts in bytes. It decides whether the first byte after a Start addresses this device. It then drives the open-drain data line through an output enable, both for acknowledge bits and for read data.

On the memory side it gives a one-cycle strobe with the word address, a one-cycle strobe for each written data byte, a strobe when a read byte has been accepted by the master, and a Stop strobe for addressed transfers. The memory reports its internal write cycle through `busy_i`. While that input is high the front end stays silent on the bus, so a master can poll for completion by repeating the control byte until it is acknowledged.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is 0 and the strobes `waddr_vld_o`, `wdata_vld_o`, `rd_next_o` and `stop_o` are 0.
- R2: The first byte after a Start is acknowledged only when its bits [7:4] equal 4'b1010, its bits [3:1] equal `strap_i[2:0]` (bit 3 against `strap_i[2]`), and `busy_i` is low. Bit 0 selects a read when 1 and a write when 0. An acknowledge pulls SDA low (`sda_oe_o` = 1) for the whole ninth clock.
- R3: After a control byte that does not match, no later byte is acknowledged and no strobe fires until the next Start.
- R4: After an acknowledged write control byte, the next byte is acknowledged and presented on `waddr_o` with a one-cycle `waddr_vld_o`. Every following byte is acknowledged and presented on `wdata_o` with a one-cycle `wdata_vld_o`. No two of the strobes are ever high together.
- R5: A byte whose eighth SCL rise finds `busy_i` high is not acknowledged, raises no strobe, and ends the transfer until the next Start. A matching control byte is acknowledged again once `busy_i` is low.
- R6: After an acknowledged read control byte, the block sends `rd_data_i` MSB first, one bit per SCL clock (`sda_oe_o` = 1 for a 0 bit). It samples `rd_data_i` at the SCL fall that begins each byte. When the master acknowledges a byte at the ninth rise, `rd_next_o` pulses for one cycle.
- R7: When the master does not acknowledge a read byte, the block releases SDA, gives no `rd_next_o` pulse, and ignores traffic until the next Start.
- R8: A repeated Start at any point restarts control-byte reception.
- R9: `stop_o` pulses for one cycle on a Stop only if a control byte was acknowledged since the last Start.
- R10: `sda_oe_o` changes only while SCL is low. The change takes effect at the (`HOLD_CLKS`+1)-th clock edge after the edge at which SCL is first sampled low.
- R11: Outside acknowledge slots and read data bits, `sda_oe_o` stays 0, so master-driven bits appear unchanged on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized serial clock level |
| sda_i | input | 1 | Synchronized serial data level |
| strap_i | input | 3 | Device select strap levels |
| busy_i | input | 1 | Memory internal write cycle in progress |
| rd_data_i | input | 8 | Byte to transmit on a read |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| waddr_vld_o | output | 1 | Word address strobe |
| waddr_o | output | 8 | Received word address |
| wdata_vld_o | output | 1 | Write data strobe |
| wdata_o | output | 8 | Received data byte |
| rd_next_o | output | 1 | Master accepted the transmitted byte |
| stop_o | output | 1 | Stop seen after an addressed transfer |

## Verification
The risky overlap is a byte completing in the same system clock cycle in which `busy_i` rises. The acknowledge decision and the data strobe both depend on that single edge. The bench raises `busy_i` in the very cycle in which it raises SCL for the eighth bit of a data byte. It then requires a missing acknowledge and an unchanged write-strobe count. Separately, the bench polls with a matching control byte while `busy_i` is high and again after it falls, and expects silence and then an acknowledge.

// File: rtl/twi_eep_pkg.sv
package twi_eep_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int SEL_W  = 3;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } twi_state_t;
endpackage

// File: rtl/twi_line_mon.sv
module twi_line_mon (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moving while SCL holds high marks a bus condition
  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/twi_rx_shift.sv
module twi_rx_shift
  import twi_eep_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              scl_rise,
  input  logic              sda_i,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              ack_slot
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);

  logic [BYTE_W-2:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (en && scl_rise) begin
      if (bit_cnt == ACK_BIT) begin
        bit_cnt <= '0;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= {shreg[BYTE_W-3:0], sda_i};
      end
    end
  end

  assign rx_byte   = {shreg, sda_i};
  assign byte_done = en && scl_rise && (bit_cnt == LAST_BIT);
  assign ack_slot  = en && scl_rise && (bit_cnt == ACK_BIT);
endmodule

// File: rtl/twi_sda_drv.sv
module twi_sda_drv #(
  parameter int HOLD_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_fall,
  input  logic tgt,
  output logic oe
);
  localparam int HW = $clog2(HOLD_CLKS + 2);

  logic [HW-1:0] hold_cnt;
  logic          pend;
  logic          tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe       <= 1'b0;
      pend     <= 1'b0;
      tgt_q    <= 1'b0;
      hold_cnt <= '0;
    end else if (scl_fall) begin
      pend     <= 1'b1;
      tgt_q    <= tgt;
      hold_cnt <= HW'(HOLD_CLKS);
    end else if (pend) begin
      if (hold_cnt == '0) begin
        oe   <= tgt_q;
        pend <= 1'b0;
      end else begin
        hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_eep_pkg::*;
#(
  parameter int               HOLD_CLKS = 4,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              waddr_vld_o,
  output logic [BYTE_W-1:0] waddr_o,
  output logic              wdata_vld_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              rd_next_o,
  output logic              stop_o
);
  localparam logic [CNT_W-1:0] ACK_BIT = CNT_W'(BYTE_W);
  localparam int IDX_W = $clog2(BYTE_W);

  twi_state_t        state;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done, ack_slot;
  logic              slave_ack, sel;
  logic [BYTE_W-1:0] tx_sh;
  logic [IDX_W-1:0]  tx_idx;
  logic              ctrl_hit;
  logic              drv_tgt;

  twi_line_mon u_mon (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_rx_shift u_rx (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_det),
    .en        (state != ST_IDLE),
    .scl_rise  (scl_rise),
    .sda_i     (sda_i),
    .bit_cnt   (bit_cnt),
    .rx_byte   (rx_byte),
    .byte_done (byte_done),
    .ack_slot  (ack_slot)
  );

  assign ctrl_hit = (rx_byte[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
                    (rx_byte[SEL_W:1] == strap_i) && !busy_i;

  // Control/transfer sequencing, decided at the eighth and ninth SCL rise
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      slave_ack   <= 1'b0;
      sel         <= 1'b0;
      waddr_vld_o <= 1'b0;
      waddr_o     <= '0;
      wdata_vld_o <= 1'b0;
      wdata_o     <= '0;
      rd_next_o   <= 1'b0;
      stop_o      <= 1'b0;
    end else begin
      waddr_vld_o <= 1'b0;
      wdata_vld_o <= 1'b0;
      rd_next_o   <= 1'b0;
      stop_o      <= 1'b0;
      if (start_det) begin
        state     <= ST_CTRL;
        slave_ack <= 1'b0;
        sel       <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        slave_ack <= 1'b0;
        stop_o    <= sel;
        sel       <= 1'b0;
      end else if (byte_done) begin
        unique case (state)
          ST_CTRL: begin
            if (ctrl_hit) begin
              slave_ack <= 1'b1;
              sel       <= 1'b1;
              state     <= rx_byte[0] ? ST_RDATA : ST_ADDR;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ADDR: begin
            if (!busy_i) begin
              slave_ack   <= 1'b1;
              waddr_vld_o <= 1'b1;
              waddr_o     <= rx_byte;
              state       <= ST_WDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_WDATA: begin
            if (!busy_i) begin
              slave_ack   <= 1'b1;
              wdata_vld_o <= 1'b1;
              wdata_o     <= rx_byte;
            end else begin
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end else if (ack_slot) begin
        if (slave_ack) begin
          slave_ack <= 1'b0;
        end else if (state == ST_RDATA) begin
          if (sda_i) state <= ST_IDLE;
          else       rd_next_o <= 1'b1;
        end
      end
    end
  end

  // Transmit shift register, loaded at the fall that opens each read byte
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
    end else if (scl_fall && state == ST_RDATA && bit_cnt == '0) begin
      tx_sh <= rd_data_i;
    end
  end

  assign tx_idx = IDX_W'(BYTE_W - 1) - bit_cnt[IDX_W-1:0];

  always_comb begin
    drv_tgt = 1'b0;
    if (state != ST_IDLE) begin
      if (bit_cnt == ACK_BIT) begin
        drv_tgt = slave_ack;
      end else if (state == ST_RDATA) begin
        drv_tgt = (bit_cnt == '0) ? ~rd_data_i[BYTE_W-1] : ~tx_sh[tx_idx];
      end
    end
  end

  twi_sda_drv #(.HOLD_CLKS(HOLD_CLKS)) u_drv (
    .clk      (clk),
    .rst      (rst),
    .scl_fall (scl_fall),
    .tgt      (drv_tgt),
    .oe       (sda_oe_o)
  );
endmodule

// File: rtl/twi_eeprom_slave_chk.sv
module twi_eeprom_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_i,
  input logic busy_i,
  input logic sda_oe_o,
  input logic waddr_vld_o,
  input logic wdata_vld_o,
  input logic rd_next_o,
  input logic stop_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sda_oe_o && !waddr_vld_o && !wdata_vld_o && !rd_next_o && !stop_o); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({waddr_vld_o, wdata_vld_o, rd_next_o, stop_o})); // R4

  AST_NO_WDATA_BUSY: assert property (@(posedge clk) disable iff (rst)
    wdata_vld_o |-> !$past(busy_i)); // R5

  AST_RDNEXT_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    rd_next_o |-> $past(scl_i) && !$past(sda_i)); // R6

  AST_STOP_ON_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> $past(scl_i) && $past(sda_i)); // R9

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_i)); // R10
endmodule

bind twi_eeprom_slave twi_eeprom_slave_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .busy_i      (busy_i),
  .sda_oe_o    (sda_oe_o),
  .waddr_vld_o (waddr_vld_o),
  .wdata_vld_o (wdata_vld_o),
  .rd_next_o   (rd_next_o),
  .stop_o      (stop_o)
);

// File: tb/twi_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module twi_eeprom_slave_tb_top;
  localparam int HOLD = 4;
  localparam int Q    = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic       clk = 1'b0;
  logic       rst;
  logic       scl_m, sda_m, busy_i;
  logic [7:0] rd_val;
  logic       sda_w;
  logic       sda_oe_o, waddr_vld_o, wdata_vld_o, rd_next_o, stop_o;
  logic [7:0] waddr_o, wdata_o;

  int checks = 0;
  int errors = 0;
  int n_waddr = 0, n_wdata = 0, n_rdnext = 0, n_stop = 0;
  logic [7:0] last_waddr;
  logic [7:0] wlog [0:63];
  logic [7:0] exp_rd;

  always #2.5 clk = ~clk;

  assign sda_w = sda_m & ~sda_oe_o;

  twi_eeprom_slave #(.HOLD_CLKS(HOLD)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_m),
    .sda_i       (sda_w),
    .strap_i     (STRAP),
    .busy_i      (busy_i),
    .rd_data_i   (rd_val),
    .sda_oe_o    (sda_oe_o),
    .waddr_vld_o (waddr_vld_o),
    .waddr_o     (waddr_o),
    .wdata_vld_o (wdata_vld_o),
    .wdata_o     (wdata_o),
    .rd_next_o   (rd_next_o),
    .stop_o      (stop_o)
  );

  function automatic logic [7:0] next_rd(input logic [7:0] v);
    return v * 8'd5 + 8'd3;
  endfunction

  function automatic logic [7:0] ctrl(input logic [3:0] code, input logic [2:0] s, input logic rw);
    return {code, s, rw};
  endfunction

  always @(posedge clk) begin
    if (rst) rd_val <= 8'h3C;
    else if (rd_next_o) rd_val <= next_rd(rd_val);
    if (!rst) begin
      if (waddr_vld_o) begin n_waddr++; last_waddr <= waddr_o; end
      if (wdata_vld_o) begin wlog[n_wdata % 64] <= wdata_o; n_wdata++; end
      if (rd_next_o) n_rdnext++;
      if (stop_o) n_stop++;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic mb, input logic busy_now, output logic seen);
    tick(Q); sda_m = mb;
    tick(Q); scl_m = 1'b1; if (busy_now) busy_i = 1'b1;
    tick(Q); seen = sda_w;
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    tick(Q); sda_m = 1'b1;
    tick(Q); scl_m = 1'b1;
    tick(Q); sda_m = 1'b0;
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0;
    tick(Q); scl_m = 1'b1;
    tick(Q); sda_m = 1'b1;
    tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic hold_chk, input logic busy_last,
                           output logic ack);
    logic s;
    logic clean = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], busy_last && (i == 0), s);
      if (s != b[i]) clean = 1'b0;
    end
    chk(clean, "R11 line follows master bits", int'(clean), 1);
    if (hold_chk) begin
      repeat (HOLD + 1) @(negedge clk);
      chk(sda_oe_o == 1'b0, "R10 oe before hold expires", int'(sda_oe_o), 0);
      @(negedge clk);
      chk(sda_oe_o == 1'b1, "R10 oe after hold expires", int'(sda_oe_o), 1);
    end
    clk_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    clk_bit(!mack, 1'b0, s);
  endtask

  task automatic do_write(input logic [7:0] addr, input int nb, input logic hold_chk);
    logic ack;
    logic [7:0] d;
    int w0, d0, s0;
    bus_start();
    send_byte(ctrl(4'b1010, STRAP, 1'b0), hold_chk, 1'b0, ack);
    chk(ack, "R2 write control ack", int'(ack), 1);
    w0 = n_waddr;
    send_byte(addr, 1'b0, 1'b0, ack);
    chk(ack, "R4 address ack", int'(ack), 1);
    chk(n_waddr == w0 + 1 && last_waddr == addr, "R4 address strobe", int'(last_waddr), int'(addr));
    for (int k = 0; k < nb; k++) begin
      d = 8'($urandom);
      d0 = n_wdata;
      send_byte(d, 1'b0, 1'b0, ack);
      chk(ack, "R4 data ack", int'(ack), 1);
      chk(n_wdata == d0 + 1 && wlog[d0 % 64] == d, "R4 data strobe", int'(wlog[d0 % 64]), int'(d));
    end
    s0 = n_stop;
    bus_stop();
    chk(n_stop == s0 + 1, "R9 stop after addressed write", n_stop - s0, 1);
  endtask

  task automatic do_read(input logic [7:0] addr, input int nb);
    logic ack;
    logic [7:0] b;
    int r0;
    bus_start();
    send_byte(ctrl(4'b1010, STRAP, 1'b0), 1'b0, 1'b0, ack);
    send_byte(addr, 1'b0, 1'b0, ack);
    bus_start();
    send_byte(ctrl(4'b1010, STRAP, 1'b1), 1'b0, 1'b0, ack);
    chk(ack, "R8 read control after repeated start", int'(ack), 1);
    r0 = n_rdnext;
    for (int k = 0; k < nb; k++) begin
      recv_byte(k != nb - 1, b);
      chk(b == exp_rd, "R6 read byte value", int'(b), int'(exp_rd));
      if (k != nb - 1) exp_rd = next_rd(exp_rd);
    end
    chk(n_rdnext == r0 + nb - 1, "R7 rd_next count after nack", n_rdnext - r0, nb - 1);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R7 released after master nack", int'(b), 8'hFF);
    chk(n_rdnext == r0 + nb - 1, "R7 no advance after nack", n_rdnext - r0, nb - 1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int w0, d0, s0, seed;
    seed = $urandom(32'd4242);
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; busy_i = 1'b0;
    exp_rd = 8'h3C;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!sda_oe_o && !waddr_vld_o && !wdata_vld_o && !rd_next_o && !stop_o,
        "R1 reset outputs", int'(sda_oe_o), 0);

    // directed write with the output hold window measured on the control ack
    do_write(8'h5A, 3, 1'b1);
    for (int t = 0; t < 3; t++) do_write(8'($urandom), 1 + int'($urandom % 4), 1'b0);

    // wrong device code, then traffic that must be ignored
    bus_start();
    send_byte(ctrl(4'b1011, STRAP, 1'b0), 1'b0, 1'b0, ack);
    chk(!ack, "R2 wrong code not acked", int'(ack), 0);
    w0 = n_waddr; d0 = n_wdata; s0 = n_stop;
    send_byte(8'h10, 1'b0, 1'b0, ack);
    chk(!ack, "R3 ignored after mismatch", int'(ack), 0);
    send_byte(8'h22, 1'b0, 1'b0, ack);
    chk(n_waddr == w0 && n_wdata == d0, "R3 no strobes after mismatch", n_waddr - w0, 0);
    bus_stop();
    chk(n_stop == s0, "R9 no stop strobe when unaddressed", n_stop - s0, 0);

    // wrong strap, then repeated start with the right one
    bus_start();
    send_byte(ctrl(4'b1010, STRAP ^ 3'b100, 1'b0), 1'b0, 1'b0, ack);
    chk(!ack, "R2 wrong strap not acked", int'(ack), 0);
    bus_start();
    send_byte(ctrl(4'b1010, STRAP, 1'b0), 1'b0, 1'b0, ack);
    chk(ack, "R8 repeated start after mismatch", int'(ack), 1);
    bus_stop();

    // acknowledge polling against busy
    busy_i = 1'b1;
    bus_start();
    send_byte(ctrl(4'b1010, STRAP, 1'b0), 1'b0, 1'b0, ack);
    chk(!ack, "R5 silent while busy", int'(ack), 0);
    bus_stop();
    busy_i = 1'b0;
    bus_start();
    send_byte(ctrl(4'b1010, STRAP, 1'b0), 1'b0, 1'b0, ack);
    chk(ack, "R5 acked after busy clears", int'(ack), 1);
    bus_stop();

    // busy rises in the same cycle as the eighth rise of a data byte
    bus_start();
    send_byte(ctrl(4'b1010, STRAP, 1'b0), 1'b0, 1'b0, ack);
    send_byte(8'h40, 1'b0, 1'b0, ack);
    d0 = n_wdata;
    send_byte(8'hC3, 1'b0, 1'b1, ack);
    chk(!ack, "R5 busy at byte end not acked", int'(ack), 0);
    chk(n_wdata == d0, "R5 no data strobe when busy", n_wdata - d0, 0);
    bus_stop();
    busy_i = 1'b0;

    // reads: directed and random lengths
    do_read(8'h00, 1);
    do_read(8'h80, 4);
    for (int t = 0; t < 2; t++) do_read(8'($urandom), 2 + int'($urandom % 4));

    tick(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule